// File: doc/BRIEF.md
# Two-wire serial memory slave controller

This block is the bus-facing front end of a 256-byte serial memory. It watches the two-wire clock and data lines through a synchroniser and a small digital glitch filter, all clocked by a faster system clock. It finds START and STOP conditions and checks each control byte against three chip-select pins. It holds the byte address pointer and runs byte writes, page writes, current-address reads, random reads and sequential reads. The block drives the data line only through an open-drain enable.

Array traffic leaves the block on a simple request interface. A write request carries the address and data of every received data byte, aimed at a page buffer. After a write transaction, a STOP gives a one-cycle commit strobe. Reads present the pointer on an address output and take the byte back combinationally. A second control code writes a protect register and has its own commit strobe. While the array reports a write cycle in progress, no control byte is acknowledged, so a master can poll for completion.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A falling data line while the filtered clock is high (START) restarts control-byte reception from any state. A rising data line while the clock is high (STOP) ends the transaction and releases the data line.
- R2: The control byte is received MSB first. Bits 7..4 are the code, bits 3..1 are compared with `cs_pins[2:0]`, and bit 0 is read (1) or write (0). It is acknowledged (data held low during the 9th clock) only when the select bits match and the code is 1010 with either direction, or 0110 with write.
- R3: When `busy_i` is high at the end of the control byte, that byte and all later bytes up to the next START get no acknowledge, and no request or commit is issued.
- R4: In a write, the byte after the control byte is acknowledged and loads the pointer. Each later byte is acknowledged and produces one `wr_req` pulse, with `wr_addr` equal to the pointer and `wr_data` equal to the byte.
- R5: After each written data byte, the pointer's low 4 bits increment modulo 16 and its high 4 bits are kept, so writes wrap inside a 16-byte page.
- R6: A STOP after at least one data byte gives one `wr_commit` pulse for code 1010, or one `prot_commit` pulse for code 0110. The 0110 path never produces `wr_req` and leaves the pointer unchanged.
- R7: A read sends the byte at the pointer, MSB first, then advances the pointer by one modulo 256. A current-address read therefore returns the byte after the last one accessed.
- R8: In a read, a master acknowledge after a byte starts the next byte. A master non-acknowledge releases the line, and nothing more is driven until the next START.
- R9: A repeated START after the address byte keeps the loaded pointer, so a following read starts at that address.
- R10: The data-line enable changes only while the filtered clock is low, and only `HOLD_CYC` system clocks after a clock falling edge is seen.
- R11: A pulse on either line shorter than `FILT_LEN` system clocks has no effect on the received data.
- R12: After reset the data line is released, the pointer is 00h, and no request or commit is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the bus clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe | output | 1 | Open-drain enable; 1 pulls the data line low |
| cs_pins | input | 3 | Chip-select levels compared with control bits 3..1 |
| busy_i | input | 1 | Internal array write cycle in progress |
| rd_addr | output | 8 | Read address (current pointer) |
| rd_data | input | 8 | Array byte at `rd_addr`, combinational |
| rd_req | output | 1 | Pulse when a read byte is taken from `rd_data` |
| wr_req | output | 1 | Pulse per received data byte |
| wr_addr | output | 8 | Address for `wr_req` |
| wr_data | output | 8 | Data for `wr_req` |
| wr_commit | output | 1 | Pulse: start the array write cycle |
| prot_commit | output | 1 | Pulse: set the protect register |

## Verification
The hardest case to reach from the ports is a glitch inside a clock-high phase in the middle of a data byte. Only an extra-bit error or a changed byte shows it. The bench pulls the clock line low for two system clocks in the middle of every high phase of a written byte, then reads the byte back. Page wrap and the FFh to 00h read wrap come from directed transfers that run 20 bytes into a page and start a read at FEh. Random transfers in between keep a bench model of the pointer, and every current-address read checks that model.

// File: rtl/i2c_ee_pkg.sv
// Package: shared state type for the serial memory slave.
// Assumes an 8-bit data path; state names are private to this block.
package i2c_ee_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,   // ignore bus until START
        ST_CTRL,   // receiving control byte
        ST_CACK,   // acknowledge slot after control byte
        ST_ADDR,   // receiving word address
        ST_AACK,   // acknowledge slot after address
        ST_WDATA,  // receiving write data
        ST_DACK,   // acknowledge slot after data
        ST_TX,     // sending a read byte
        ST_TACK    // sampling master acknowledge
    } ee_state_t;
endpackage

// File: rtl/i2c_ee_glitch.sv
// Synchroniser plus persistence filter for one bus line.
// The output follows the input only after LEN consecutive equal samples.
// Assumes the line idles high; reset value is 1.
module i2c_ee_glitch #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(LEN + 1);

    logic       s1_q, s2_q;
    logic [CW-1:0] cnt_q;

    // two-flop synchroniser
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
        end
    end

    // persistence counter: accept a new level after LEN differing samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dout  <= 1'b1;
        end else if (s2_q != dout) begin
            if (cnt_q == CW'(LEN - 1)) begin
                dout  <= s2_q;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    // R11: a filtered change always agrees with the synchronised input
    p_filter_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dout != $past(dout)) |-> ($past(s2_q) == dout));
endmodule

// File: rtl/i2c_ee_events.sv
// Edge and bus-condition detector on the filtered lines.
// Produces one-cycle pulses for clock edges, START and STOP.
module i2c_ee_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic scl_q, sda_q;

    // previous-sample registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    assign scl_rise  = scl & ~scl_q;
    assign scl_fall  = ~scl & scl_q;
    assign start_evt = scl & scl_q & sda_q & ~sda;
    assign stop_evt  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/i2c_ee_sda_drv.sv
// Delayed open-drain driver: a requested level takes effect HOLD system
// clocks after the request, so changes land well inside the clock-low phase.
// A clear drops the enable at once (START/STOP).
module i2c_ee_sda_drv #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic pull_low,
    input  logic clear,
    output logic oe
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] cnt_q;
    logic          pend_q;

    // hold-off counter and pending level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
            oe     <= 1'b0;
        end else if (clear) begin
            cnt_q <= '0;
            oe    <= 1'b0;
        end else if (load) begin
            cnt_q  <= CW'(HOLD);
            pend_q <= pull_low;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) oe <= pend_q;
        end
    end
endmodule

// File: rtl/i2c_eeprom_slave.sv
// Serial memory slave protocol engine (top).
// Decodes control bytes, keeps the byte pointer and sequences writes and
// reads; array access goes through request pulses. Assumes clk runs at
// least ~20x the bus clock so filter and hold delays fit in a low phase.
module i2c_eeprom_slave
    import i2c_ee_pkg::*;
#(
    parameter int         FILT_LEN   = 4,
    parameter int         HOLD_CYC   = 4,
    parameter int         AW         = 8,
    parameter int         PAGE_W     = 4,
    parameter logic [3:0] CODE_ARRAY = 4'b1010,
    parameter logic [3:0] CODE_PROT  = 4'b0110
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    input  logic [2:0]    cs_pins,
    input  logic          busy_i,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data,
    output logic          rd_req,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          wr_commit,
    output logic          prot_commit
);
    localparam int DW = 8;
    localparam int BW = $clog2(DW + 1);

    logic scl_f, sda_f, scl_rise, scl_fall, start_evt, stop_evt;
    logic drv_load, drv_low;

    ee_state_t     state_q;
    logic [BW-1:0] bit_q;
    logic [DW-1:0] sh_q, tx_q;
    logic [AW-1:0] ptr_q;
    logic          prot_q, read_q, seen_q, mack_q;

    i2c_ee_glitch #(.LEN(FILT_LEN)) u_scl_f (.clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_f));
    i2c_ee_glitch #(.LEN(FILT_LEN)) u_sda_f (.clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_f));

    i2c_ee_events u_evt (
        .clk(clk), .rst_n(rst_n), .scl(scl_f), .sda(sda_f),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    i2c_ee_sda_drv #(.HOLD(HOLD_CYC)) u_drv (
        .clk(clk), .rst_n(rst_n), .load(drv_load), .pull_low(drv_low),
        .clear(start_evt | stop_evt), .oe(sda_oe)
    );

    assign rd_addr = ptr_q;

    logic ctrl_ok;
    assign ctrl_ok = (sh_q[3:1] == cs_pins) && !busy_i &&
                     ((sh_q[7:4] == CODE_ARRAY) ||
                      (sh_q[7:4] == CODE_PROT && !sh_q[0]));

    // protocol sequencer: bit counting, acknowledge decisions, pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;  bit_q <= '0;   sh_q <= '0;  tx_q <= '0;
            ptr_q <= '0;  prot_q <= 1'b0;  read_q <= 1'b0;  seen_q <= 1'b0;
            mack_q <= 1'b0;  drv_load <= 1'b0;  drv_low <= 1'b0;
            rd_req <= 1'b0;  wr_req <= 1'b0;  wr_addr <= '0;  wr_data <= '0;
            wr_commit <= 1'b0;  prot_commit <= 1'b0;
        end else begin
            drv_load <= 1'b0;  rd_req <= 1'b0;  wr_req <= 1'b0;
            wr_commit <= 1'b0; prot_commit <= 1'b0;
            if (start_evt) begin
                state_q <= ST_CTRL;  bit_q <= '0;  seen_q <= 1'b0;
            end else if (stop_evt) begin
                state_q <= ST_IDLE;  seen_q <= 1'b0;
                if (seen_q) begin
                    wr_commit   <= !prot_q;
                    prot_commit <= prot_q;
                end
            end else begin
                unique case (state_q)
                    ST_CTRL, ST_ADDR, ST_WDATA: begin
                        if (scl_rise) begin
                            sh_q  <= {sh_q[DW-2:0], sda_f};
                            bit_q <= bit_q + 1'b1;
                        end
                        if (scl_fall && bit_q == BW'(DW)) begin
                            bit_q    <= '0;
                            drv_load <= 1'b1;
                            drv_low  <= 1'b1;
                            if (state_q == ST_CTRL) begin
                                drv_low <= ctrl_ok;
                                state_q <= ctrl_ok ? ST_CACK : ST_IDLE;
                                prot_q  <= (sh_q[7:4] == CODE_PROT);
                                read_q  <= sh_q[0];
                            end else if (state_q == ST_ADDR) begin
                                state_q <= ST_AACK;
                                if (!prot_q) ptr_q <= sh_q;
                            end else begin
                                state_q <= ST_DACK;
                                seen_q  <= 1'b1;
                                if (!prot_q) begin
                                    wr_req  <= 1'b1;
                                    wr_addr <= ptr_q;
                                    wr_data <= sh_q;
                                    ptr_q   <= {ptr_q[AW-1:PAGE_W], ptr_q[PAGE_W-1:0] + 1'b1};
                                end
                            end
                        end
                    end
                    ST_CACK, ST_TACK: begin
                        if (scl_rise) mack_q <= ~sda_f;
                        if (scl_fall) begin
                            drv_load <= 1'b1;
                            bit_q    <= '0;
                            if ((state_q == ST_CACK && read_q) || (state_q == ST_TACK && mack_q)) begin
                                tx_q    <= rd_data;
                                rd_req  <= 1'b1;
                                ptr_q   <= ptr_q + 1'b1;
                                drv_low <= ~rd_data[DW-1];
                                state_q <= ST_TX;
                            end else begin
                                drv_low <= 1'b0;
                                state_q <= (state_q == ST_CACK) ? ST_ADDR : ST_IDLE;
                            end
                        end
                    end
                    ST_AACK, ST_DACK: begin
                        if (scl_fall) begin
                            drv_load <= 1'b1;
                            drv_low  <= 1'b0;
                            state_q  <= ST_WDATA;
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) bit_q <= bit_q + 1'b1;
                        if (scl_fall) begin
                            drv_load <= 1'b1;
                            if (bit_q == BW'(DW)) begin
                                drv_low <= 1'b0;
                                state_q <= ST_TACK;
                            end else begin
                                tx_q    <= {tx_q[DW-2:0], 1'b0};
                                drv_low <= ~tx_q[DW-2];
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R10: the slave only starts pulling the line low while the clock is low
    p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe && !$past(sda_oe)) |-> !scl_f);
    // R6: a commit strobe follows a STOP seen on the previous cycle
    p_commit_after_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit || prot_commit) |-> $past(stop_evt));
    // R6: never both commit kinds at once
    p_commit_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_commit, prot_commit}));
    // R4: write requests and read loads never coincide
    p_req_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_req && rd_req));
endmodule

// File: tb/i2c_eeprom_slave_tb.sv
module i2c_eeprom_slave_tb;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
    logic [2:0] cs = 3'b101;
    logic sda_oe, rd_req, wr_req, wr_commit, prot_commit;
    logic [7:0] rd_addr, wr_addr, wr_data, rd_data;
    wire  sda_bus = sda_m & ~sda_oe;

    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    logic [7:0] exp_ptr;
    int n_chk = 0, n_fail = 0, n_wr = 0, n_wc = 0, n_pc = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    i2c_eeprom_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .cs_pins(cs), .busy_i(busy), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_req(rd_req), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_commit(wr_commit), .prot_commit(prot_commit)
    );

    assign rd_data = mem[rd_addr];

    // array model driven by the write requests, plus strobe counters
    always @(posedge clk) begin
        if (wr_req) begin mem[wr_addr] <= wr_data; n_wr++; end
        if (wr_commit) n_wc++;
        if (prot_commit) n_pc++;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic w(input int n); repeat (n) @(negedge clk); endtask

    task automatic bus_start; sda_m = 1; w(Q); scl_m = 1; w(Q); sda_m = 0; w(Q); scl_m = 0; endtask
    task automatic bus_stop;  sda_m = 0; w(Q); scl_m = 1; w(Q); sda_m = 1; w(2*Q); endtask

    task automatic bit_w(input logic b, input logic glitch);
        w(Q); sda_m = b; w(Q); scl_m = 1;
        if (glitch) begin w(Q - 1); scl_m = 0; w(2); scl_m = 1; w(Q - 1); end
        else w(2*Q);
        scl_m = 0;
    endtask

    task automatic bit_r(output logic b);
        sda_m = 1; w(2*Q); scl_m = 1; w(Q); b = sda_bus; w(Q); scl_m = 0;
    endtask

    task automatic byte_w(input logic [7:0] d, input logic glitch, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_w(d[i], glitch);
        bit_r(b);
        ack = ~b;
    endtask

    task automatic byte_r(input logic more, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) bit_r(d[i]);
        bit_w(~more, 1'b0);
    endtask

    function automatic logic [7:0] ctrl(input logic [3:0] code, input logic rw);
        return {code, cs, rw};
    endfunction

    function automatic logic [7:0] page_next(input logic [7:0] p);
        return {p[7:4], p[3:0] + 4'd1};
    endfunction

    task automatic do_write(input logic [7:0] addr, input int n, input logic glitch);
        logic ack; int wr0, wc0;
        wr0 = n_wr; wc0 = n_wc;
        bus_start;
        byte_w(ctrl(4'b1010, 0), 0, ack); chk(ack, "R2 write ctrl ack", ack, 1);
        byte_w(addr, 0, ack);             chk(ack, "R4 addr ack", ack, 1);
        exp_ptr = addr;
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = 8'($urandom);
            byte_w(d, glitch, ack);
            chk(ack, "R4 data ack", ack, 1);
            exp_mem[exp_ptr] = d;
            exp_ptr = page_next(exp_ptr);   // R5 page wrap
        end
        bus_stop;
        chk(n_wr - wr0 == n, "R4 wr_req count", n_wr - wr0, n);
        chk(n_wc - wc0 == (n > 0 ? 1 : 0), "R6 wr_commit", n_wc - wc0, n > 0);
    endtask

    task automatic read_bytes(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            byte_r(i != n - 1, d);
            chk(d == exp_mem[exp_ptr], tag, d, exp_mem[exp_ptr]);
            exp_ptr = exp_ptr + 8'd1;
        end
    endtask

    task automatic do_cur_read(input int n);
        logic ack;
        bus_start;
        byte_w(ctrl(4'b1010, 1), 0, ack); chk(ack, "R2 read ctrl ack", ack, 1);
        read_bytes(n, "R7 R8 sequential data");
        w(2); chk(sda_oe == 0, "R8 released after nack", sda_oe, 0);
        bus_stop;
    endtask

    task automatic do_rand_read(input logic [7:0] addr, input int n);
        logic ack;
        bus_start;
        byte_w(ctrl(4'b1010, 0), 0, ack);
        byte_w(addr, 0, ack);
        exp_ptr = addr;
        bus_start;                       // R9 repeated START keeps pointer
        byte_w(ctrl(4'b1010, 1), 0, ack); chk(ack, "R9 reread ctrl ack", ack, 1);
        read_bytes(n, "R9 random read data");
        bus_stop;
    endtask

    initial begin
        logic ack;
        int wr0, wc0, pc0;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 256; i++) begin mem[i] = 8'(i * 7 + 3); exp_mem[i] = 8'(i * 7 + 3); end
        exp_ptr = 8'h00;
        w(5); rst_n = 1; w(1);
        chk(sda_oe == 0 && !wr_req && !wr_commit && !prot_commit && !rd_req, "R12 reset outputs", sda_oe, 0);
        chk(rd_addr == 8'h00, "R12 reset pointer", rd_addr, 0);

        do_cur_read(2);                                     // R7 from pointer 00h

        do_write(8'h3C, 20, 0);                             // R5 page wrap, last 16 kept
        chk(exp_ptr == 8'h30, "R5 pointer after wrap", exp_ptr, 8'h30);
        do_cur_read(3);
        do_rand_read(8'h30, 16);
        do_rand_read(8'hFE, 4);                             // R7 wrap FFh to 00h

        // R11 glitched write clock, then read back
        do_write(8'h81, 3, 1);
        do_rand_read(8'h81, 3);

        // R2 chip-select mismatch: no ack, pointer untouched
        wr0 = n_wr;
        cs = 3'b101; bus_start;
        byte_w({4'b1010, 3'b010, 1'b0}, 0, ack); chk(!ack, "R2 cs mismatch nack", ack, 0);
        byte_w(8'h55, 0, ack); chk(!ack, "R2 ignored after nack", ack, 0);
        bus_stop;
        chk(n_wr == wr0, "R2 no write on mismatch", n_wr - wr0, 0);
        do_cur_read(1);

        // R2 protect code with read bit
        bus_start; byte_w(ctrl(4'b0110, 1), 0, ack); chk(!ack, "R2 0110 read nack", ack, 0); bus_stop;

        // R6 protect write path
        wr0 = n_wr; wc0 = n_wc; pc0 = n_pc;
        bus_start;
        byte_w(ctrl(4'b0110, 0), 0, ack); chk(ack, "R6 prot ctrl ack", ack, 1);
        byte_w(8'h10, 0, ack); chk(ack, "R6 prot addr ack", ack, 1);
        byte_w(8'hA5, 0, ack); chk(ack, "R6 prot data ack", ack, 1);
        bus_stop;
        chk(n_pc - pc0 == 1, "R6 prot_commit", n_pc - pc0, 1);
        chk(n_wr == wr0 && n_wc == wc0, "R6 no array write", n_wr - wr0, 0);
        do_cur_read(1);                                     // pointer unchanged

        // R3 busy: acknowledge polling
        busy = 1; wr0 = n_wr; wc0 = n_wc;
        bus_start;
        byte_w(ctrl(4'b1010, 0), 0, ack); chk(!ack, "R3 busy nack", ack, 0);
        byte_w(8'h20, 0, ack);            chk(!ack, "R3 busy byte nack", ack, 0);
        byte_w(8'h99, 0, ack);
        bus_stop;
        chk(n_wr == wr0 && n_wc == wc0, "R3 no write while busy", n_wr - wr0, 0);
        busy = 0;
        bus_start; byte_w(ctrl(4'b1010, 0), 0, ack); chk(ack, "R3 ack after busy", ack, 1); bus_stop;

        // R1 START in the middle of a data byte restarts decode
        bus_start;
        byte_w(ctrl(4'b1010, 0), 0, ack);
        byte_w(8'h44, 0, ack);
        bit_w(1, 0); bit_w(0, 0); bit_w(1, 0);
        exp_ptr = 8'h44;
        bus_start;
        byte_w(ctrl(4'b1010, 1), 0, ack); chk(ack, "R1 restart ctrl ack", ack, 1);
        read_bytes(1, "R1 read after restart");
        bus_stop;

        // random mix
        for (int k = 0; k < 12; k++) begin
            int op;
            op = $urandom_range(2);
            if (op == 0) do_write(8'($urandom), $urandom_range(1, 6), 0);
            else if (op == 1) do_cur_read($urandom_range(1, 4));
            else do_rand_read(8'($urandom), $urandom_range(1, 4));
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule